// File: doc/BRIEF.md
# Token-Sequenced Instruction Fetch Unit

This unit paces a processor that has no free-running instruction clock. Control moves as a token. An execution unit finishes its work and returns a PC-update request to this block. The block then works out the new program counter and reads the instruction word at that address from a synchronous memory. It drives the word onto the operation bus and waits a fixed number of cycles so that downstream operand selection can settle. Finally it fires a one-cycle operation pulse, which hands the token to whichever execution unit decodes the word.

An update request carries one of four kinds. The first steps the PC by one. The second adds a signed operand to the PC. The third loads the operand into the PC. The fourth keeps the PC and uses a word supplied with the request as the instruction in place of a memory fetch.

The block also owns the interrupt state. An interrupt input raises a pending flag. When interrupts are enabled, the next request that is not an execute request diverts to a vector address and saves the would-be PC as the return site. Only jump requests can turn the enable on or off. A hold input holds back the pulse. An opcode of zero, or one above the defined range, parks the unit until reset.

Top module: `pulse_fetch_unit`

## Requirements
- R1: After reset the PC, return site, interrupt-enable and pending flags, operation word, operation pulse, read enable and halted flag are all zero, and the unit accepts a request.
- R2: The PC update is selected by `upd_kind`: 0 sets PC+1, 1 sets PC+`upd_operand` (modulo 2^ADDR_W, so the operand acts as a signed offset), 2 sets `upd_operand`, and 3 leaves the PC unchanged. The new PC shows on `status` at the edge that accepts the request.
- R3: For kinds 0 to 2, `mem_rd_en` is high for exactly the one cycle after acceptance, with `mem_rd_addr` equal to the new PC. The data returns one cycle later and is placed on `op_word` at the following edge.
- R4: For kind 3, `upd_word` appears on `op_word` at the accepting edge. No memory read is made and the PC does not change.
- R5: `op_pulse` is high for exactly one cycle. It rises SETTLE_CYC edges after `op_word` took the new instruction, provided hold was low in the cycle before that edge.
- R6: While `hold` is high, no pulse is issued. The pulse follows at the first edge after a cycle with `hold` low.
- R7: With interrupts enabled and a request pending, a request of kind 0, 1 or 2 saves the PC it would have produced as the return site, loads the PC from `irq_vector`, fetches from that address, and clears the pending flag.
- R8: An execute request never takes a pending interrupt. The PC and the pending flag are left as they were.
- R9: The enable changes only on a request of kind 1 or 2. An `upd_irq_ctl` value of 01 sets it and 11 clears it, and other values leave it as it is. `upd_irq_ctl` on kinds 0 and 3 has no effect. The interrupt decision for a jump uses the enable as it was before that jump.
- R10: `irq_raise` sets the pending flag at the next edge. If it coincides with an interrupt being taken, the flag stays set.
- R11: When the settled instruction has an opcode (`op_word[7:0]`) of 0 or above OP_LAST (120), no pulse is issued. `halted` rises at the edge where the pulse would have fired, and every later request is ignored until reset.
- R12: A request that arrives while a fetch, settle or hold wait is in progress is ignored.
- R13: `status` is {interrupt enable, interrupt pending, return site, PC}, with the PC in the low ADDR_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | PC-update request strobe (the returning token) |
| upd_kind | input | 2 | 0 step, 1 relative, 2 absolute, 3 execute supplied word |
| upd_operand | input | ADDR_W | Offset or target for jumps |
| upd_word | input | DATA_W | Instruction word for an execute request |
| upd_irq_ctl | input | 2 | 01 enable, 11 disable interrupts (jumps only) |
| hold | input | 1 | Withholds the operation pulse while high |
| irq_raise | input | 1 | Marks an interrupt request as pending |
| irq_vector | input | ADDR_W | Interrupt handler address |
| mem_rd_en | output | 1 | Instruction memory read enable |
| mem_rd_addr | output | ADDR_W | Instruction memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the read |
| op_word | output | DATA_W | Current instruction on the operation bus |
| op_pulse | output | 1 | One-cycle start pulse for execution units |
| halted | output | 1 | Unit stopped on an illegal opcode |
| status | output | 2*ADDR_W+2 | {enable, pending, return site, PC} |

## Verification
A corrupted PC or return site shows on `status` at the edge that accepts the request, and on `mem_rd_addr` one cycle later. A wrong sequencer phase moves the pulse away from its expected edge, or lets a stray request change the PC, within the same fetch. A wrong interrupt flag becomes visible only at the next request, which jumps to the vector when it should not, or fails to jump when it should. For that reason every flag change is followed by a request. The reference model is compared against every output on every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

  typedef enum logic [1:0] {
    UPD_STEP = 2'd0,
    UPD_REL  = 2'd1,
    UPD_ABS  = 2'd2,
    UPD_EXEC = 2'd3
  } upd_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_LATCH  = 3'd2,
    PH_SETTLE = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  localparam logic [1:0] IRQ_CTL_ON  = 2'b01;
  localparam logic [1:0] IRQ_CTL_OFF = 2'b11;

endpackage

// File: rtl/pfu_pc_unit.sv
module pfu_pc_unit
  import pfu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  upd_kind_e         kind,
  input  logic [ADDR_W-1:0] operand,
  input  logic [1:0]        irq_ctl,
  input  logic              irq_raise,
  input  logic [ADDR_W-1:0] irq_vector,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ret_site,
  output logic              irq_en,
  output logic              irq_pend
);

  logic [ADDR_W-1:0] pc_next;
  logic              moves_pc;
  logic              is_jump;
  logic              divert;

  always_comb begin
    case (kind)
      UPD_STEP: pc_next = pc + ADDR_W'(1);
      UPD_REL:  pc_next = pc + operand;
      UPD_ABS:  pc_next = operand;
      default:  pc_next = pc;
    endcase
    moves_pc = accept && (kind != UPD_EXEC);
    is_jump  = accept && ((kind == UPD_REL) || (kind == UPD_ABS));
    divert   = moves_pc && irq_en && irq_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ret_site <= '0;
    end else if (moves_pc) begin
      if (divert) begin
        ret_site <= pc_next;
        pc       <= irq_vector;
      end else begin
        pc <= pc_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en <= 1'b0;
    end else if (is_jump) begin
      if (irq_ctl == IRQ_CTL_ON)       irq_en <= 1'b1;
      else if (irq_ctl == IRQ_CTL_OFF) irq_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            irq_pend <= 1'b0;
    else if (irq_raise) irq_pend <= 1'b1;
    else if (divert)    irq_pend <= 1'b0;
  end

  AST_EXEC_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == UPD_EXEC) |=> $stable(pc)); // R4

  AST_EXEC_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == UPD_EXEC && !irq_raise) |=> $stable(irq_pend)); // R8

  AST_IRQ_DIVERT: assert property (@(posedge clk) disable iff (rst)
    (accept && kind != UPD_EXEC && irq_en && irq_pend && !irq_raise)
      |=> (!irq_pend && pc == $past(irq_vector))); // R7

  AST_IE_ONLY_JUMP: assert property (@(posedge clk) disable iff (rst)
    !(accept && (kind == UPD_REL || kind == UPD_ABS)) |=> $stable(irq_en)); // R9

  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (rst)
    irq_raise |=> irq_pend); // R10

endmodule

// File: rtl/pfu_op_check.sv
module pfu_op_check #(
  parameter int OPC_W   = 8,
  parameter int OP_LAST = 120
) (
  input  logic [OPC_W-1:0] opcode,
  output logic             legal
);

  localparam int OPC_MAX = (1 << OPC_W) - 1;

  logic nonzero;
  assign nonzero = (opcode != '0);

  generate
    if (OP_LAST >= OPC_MAX) begin : g_full_range
      assign legal = nonzero;
    end else begin : g_bounded
      localparam logic [OPC_W-1:0] LAST_V = OPC_W'(OP_LAST);
      assign legal = nonzero && (opcode <= LAST_V);
    end
  endgenerate

endmodule

// File: rtl/pfu_sequencer.sv
module pfu_sequencer
  import pfu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  upd_kind_e         kind,
  input  logic [DATA_W-1:0] upd_word,
  input  logic              hold,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              legal,
  output logic              accept,
  output logic              mem_rd_en,
  output logic [DATA_W-1:0] op_word,
  output logic              op_pulse,
  output logic              halted
);

  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             settled;

  assign accept  = (phase == PH_IDLE) && upd_valid;
  assign settled = (phase == PH_SETTLE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      op_word   <= '0;
      op_pulse  <= 1'b0;
      mem_rd_en <= 1'b0;
      halted    <= 1'b0;
    end else begin
      op_pulse  <= 1'b0;
      mem_rd_en <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            if (kind == UPD_EXEC) begin
              op_word <= upd_word;
              cnt     <= CNT_LOAD;
              phase   <= PH_SETTLE;
            end else begin
              mem_rd_en <= 1'b1;
              phase     <= PH_READ;
            end
          end
        end
        PH_READ: phase <= PH_LATCH;
        PH_LATCH: begin
          op_word <= mem_rd_data;
          cnt     <= CNT_LOAD;
          phase   <= PH_SETTLE;
        end
        PH_SETTLE: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (!legal) begin
            halted <= 1'b1;
            phase  <= PH_STOP;
          end else if (!hold) begin
            op_pulse <= 1'b1;
            phase    <= PH_IDLE;
          end
        end
        default: phase <= PH_STOP;
      endcase
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    op_pulse |=> !op_pulse); // R5

  AST_HOLD_GATES: assert property (@(posedge clk) disable iff (rst)
    hold |=> !op_pulse); // R6

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !op_pulse && !mem_rd_en)); // R11

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R3

  AST_EXEC_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == UPD_EXEC) |=> !mem_rd_en); // R4

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> !accept); // R12

  AST_SETTLE_BEFORE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(op_pulse) |-> $past(settled)); // R5

endmodule

// File: rtl/pulse_fetch_unit.sv
module pulse_fetch_unit
  import pfu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int OPC_W      = 8,
  parameter int OP_LAST    = 120,
  parameter int SETTLE_CYC = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd_valid,
  input  logic [1:0]          upd_kind,
  input  logic [ADDR_W-1:0]   upd_operand,
  input  logic [DATA_W-1:0]   upd_word,
  input  logic [1:0]          upd_irq_ctl,
  input  logic                hold,
  input  logic                irq_raise,
  input  logic [ADDR_W-1:0]   irq_vector,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic [DATA_W-1:0]   mem_rd_data,
  output logic [DATA_W-1:0]   op_word,
  output logic                op_pulse,
  output logic                halted,
  output logic [2*ADDR_W+1:0] status
);

  upd_kind_e         kind;
  logic              accept;
  logic              legal;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ret_site;
  logic              irq_en;
  logic              irq_pend;

  assign kind = upd_kind_e'(upd_kind);

  pfu_pc_unit #(.ADDR_W(ADDR_W)) i_pc (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .kind       (kind),
    .operand    (upd_operand),
    .irq_ctl    (upd_irq_ctl),
    .irq_raise  (irq_raise),
    .irq_vector (irq_vector),
    .pc         (pc),
    .ret_site   (ret_site),
    .irq_en     (irq_en),
    .irq_pend   (irq_pend)
  );

  pfu_sequencer #(.DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .upd_valid   (upd_valid),
    .kind        (kind),
    .upd_word    (upd_word),
    .hold        (hold),
    .mem_rd_data (mem_rd_data),
    .legal       (legal),
    .accept      (accept),
    .mem_rd_en   (mem_rd_en),
    .op_word     (op_word),
    .op_pulse    (op_pulse),
    .halted      (halted)
  );

  pfu_op_check #(.OPC_W(OPC_W), .OP_LAST(OP_LAST)) i_chk (
    .opcode (op_word[OPC_W-1:0]),
    .legal  (legal)
  );

  assign mem_rd_addr = pc;
  assign status      = {irq_en, irq_pend, ret_site, pc};

  AST_READ_AT_PC: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |-> $changed(pc) || $past(accept)); // R3

endmodule

// File: tb/test_pulse_fetch_unit.sv
module test_pulse_fetch_unit;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SETTLE = 3;
  localparam int LAST = 120;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd_valid = 1'b0;
  logic [1:0]    upd_kind = 2'd0;
  logic [AW-1:0] upd_operand = '0;
  logic [DW-1:0] upd_word = '0;
  logic [1:0]    upd_irq_ctl = 2'b00;
  logic          hold = 1'b0;
  logic          irq_raise = 1'b0;
  logic [AW-1:0] irq_vector = 16'd100;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic [DW-1:0] op_word;
  logic          op_pulse;
  logic          halted;
  logic [2*AW+1:0] status;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem [256];

  always #2 clk = ~clk;

  pulse_fetch_unit #(.ADDR_W(AW), .DATA_W(DW), .OP_LAST(LAST), .SETTLE_CYC(SETTLE)) i_pulse_fetch_unit (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_kind(upd_kind),
    .upd_operand(upd_operand), .upd_word(upd_word), .upd_irq_ctl(upd_irq_ctl),
    .hold(hold), .irq_raise(irq_raise), .irq_vector(irq_vector),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .op_word(op_word), .op_pulse(op_pulse), .halted(halted), .status(status)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];

  // Behavioural reference model
  int          m_phase;
  int          m_cnt;
  logic [AW-1:0] m_pc, m_ret;
  logic        m_ie, m_ip, m_pulse, m_rden, m_halt;
  logic [DW-1:0] m_word;

  function automatic bit bad_op(input logic [DW-1:0] w);
    return (w[7:0] == 8'd0) || (int'(w[7:0]) > LAST);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_pc = '0; m_ret = '0; m_ie = 0; m_ip = 0;
      m_pulse = 0; m_rden = 0; m_halt = 0; m_word = '0;
    end else begin
      logic [AW-1:0] nxt;
      bit take;
      take = 0;
      m_pulse = 0;
      m_rden = 0;
      case (m_phase)
        0: if (upd_valid) begin
          nxt = (upd_kind == 0) ? m_pc + 16'd1 : (upd_kind == 1) ? m_pc + upd_operand : upd_operand;
          if (upd_kind == 3) begin
            m_word = upd_word; m_cnt = SETTLE - 1; m_phase = 3;
          end else begin
            if (m_ie && m_ip) begin m_ret = nxt; m_pc = irq_vector; take = 1; end
            else m_pc = nxt;
            m_rden = 1; m_phase = 1;
          end
          if (upd_kind == 1 || upd_kind == 2) begin
            if (upd_irq_ctl == 2'b01) m_ie = 1;
            else if (upd_irq_ctl == 2'b11) m_ie = 0;
          end
        end
        1: m_phase = 2;
        2: begin m_word = mem[m_pc[7:0]]; m_cnt = SETTLE - 1; m_phase = 3; end
        3: begin
          if (m_cnt > 0) m_cnt--;
          else if (bad_op(m_word)) begin m_halt = 1; m_phase = 4; end
          else if (!hold) begin m_pulse = 1; m_phase = 0; end
        end
        default: ;
      endcase
      if (irq_raise) m_ip = 1;
      else if (take) m_ip = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 pc", 64'(status[AW-1:0]), 64'(m_pc));
      chk("R7 return site", 64'(status[2*AW-1:AW]), 64'(m_ret));
      chk("R10 pending", 64'(status[2*AW]), 64'(m_ip));
      chk("R9 enable", 64'(status[2*AW+1]), 64'(m_ie));
      chk("R3 op_word", 64'(op_word), 64'(m_word));
      chk("R5 op_pulse", 64'(op_pulse), 64'(m_pulse));
      chk("R3 mem_rd_en", 64'(mem_rd_en), 64'(m_rden));
      if (mem_rd_en) chk("R3 mem_rd_addr", 64'(mem_rd_addr), 64'(m_pc));
      chk("R11 halted", 64'(halted), 64'(m_halt));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<40000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic req(input int k, input logic [AW-1:0] opnd, input logic [DW-1:0] w, input logic [1:0] ctl);
    @(negedge clk);
    upd_valid = 1; upd_kind = k[1:0]; upd_operand = opnd; upd_word = w; upd_irq_ctl = ctl;
    @(negedge clk);
    upd_valid = 0; upd_irq_ctl = 2'b00;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!op_pulse && !halted && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic raise();
    @(negedge clk); irq_raise = 1;
    @(negedge clk); irq_raise = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 status", 64'(status), 64'd0);
    chk("R1 op_word", 64'(op_word), 64'd0);
    chk("R1 op_pulse", 64'(op_pulse), 64'd0);
    chk("R1 mem_rd_en", 64'(mem_rd_en), 64'd0);
    chk("R1 halted", 64'(halted), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {24'(i), 8'(1 + i % 100)};
    mem[60] = 32'h0000_1200;
    mem[61] = 32'h0000_34C8;
    do_reset();

    req(0, 0, 0, 0); wait_done();
    chk("R2 step", 64'(status[15:0]), 64'd1);
    req(1, 16'd5, 0, 0); wait_done();
    chk("R2 rel forward", 64'(status[15:0]), 64'd6);
    req(1, 16'hFFFD, 0, 0); wait_done();
    chk("R2 rel back", 64'(status[15:0]), 64'd3);
    req(2, 16'd40, 0, 0); wait_done();
    chk("R3 fetched word", 64'(op_word), 64'({24'd40, 8'd41}));
    req(3, 16'd9, 32'h0000_AB07, 0); wait_done();
    chk("R4 exec word", 64'(op_word), 64'h0000_AB07);
    chk("R4 exec keeps pc", 64'(status[15:0]), 64'd40);

    hold = 1;
    req(0, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R6 no pulse in hold", 64'(op_pulse), 64'd0);
    end
    hold = 0;
    wait_done();
    chk("R6 pc after hold", 64'(status[15:0]), 64'd41);

    req(0, 0, 0, 0);
    upd_valid = 1; upd_kind = 2; upd_operand = 16'd99;
    @(negedge clk); @(negedge clk);
    upd_valid = 0;
    wait_done();
    chk("R12 busy request ignored", 64'(status[15:0]), 64'd42);

    req(2, 16'd50, 0, 2'b01); wait_done();
    chk("R9 enable set", 64'(status[33]), 64'd1);
    raise();
    chk("R10 pending set", 64'(status[32]), 64'd1);
    req(3, 0, 32'h0000_0007, 0); wait_done();
    chk("R8 exec pc", 64'(status[15:0]), 64'd50);
    chk("R8 exec keeps pending", 64'(status[32]), 64'd1);
    req(0, 0, 0, 0); wait_done();
    chk("R7 vector", 64'(status[15:0]), 64'd100);
    chk("R7 return", 64'(status[31:16]), 64'd51);
    chk("R13 status layout", 64'(status), 64'({1'b1, 1'b0, 16'd51, 16'd100}));

    raise();
    @(negedge clk);
    upd_valid = 1; upd_kind = 0; irq_raise = 1;
    @(negedge clk);
    upd_valid = 0; irq_raise = 0;
    wait_done();
    chk("R10 raise beats clear", 64'(status[32]), 64'd1);
    chk("R7 return on second take", 64'(status[31:16]), 64'd101);
    req(0, 0, 0, 0); wait_done();
    chk("R10 cleared after take", 64'(status[32]), 64'd0);

    req(2, 16'd10, 0, 2'b11); wait_done();
    chk("R9 enable cleared", 64'(status[33]), 64'd0);
    raise();
    req(0, 0, 0, 0); wait_done();
    chk("R9 disabled no divert", 64'(status[15:0]), 64'd11);
    req(0, 0, 0, 2'b01); wait_done();
    chk("R9 ctl ignored on step", 64'(status[33]), 64'd0);

    req(2, 16'd60, 0, 0); wait_done();
    chk("R11 halted on zero", 64'(halted), 64'd1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R11 no pulse", 64'(op_pulse), 64'd0);
    end
    req(0, 0, 0, 0);
    repeat (8) @(negedge clk);
    chk("R11 request ignored", 64'(status[15:0]), 64'd60);

    do_reset();
    req(2, 16'd61, 0, 0); wait_done();
    chk("R11 halted above range", 64'(halted), 64'd1);
    do_reset();
    req(3, 0, 32'h0000_5500, 0); wait_done();
    chk("R11 halted exec zero", 64'(halted), 64'd1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule